// File: doc/BRIEF.md
# Multi-Domain Control/Status Register Bank

This block is a bank of twelve 32-bit control and status words behind a small word-addressed software port. Software selects a word with a 4-bit address. A single-cycle write strobe carries 32 bits of data. A read enable returns the selected word one clock later. Hardware logic beside the bank gets its own write strobes and data for each field, and reads back the fields that are visible to it.

The bank does not run under one clocking scheme. Each word, or replicated group of words, has its own active clock edge, reset level and reset style. Some words update on the falling edge. Some reset synchronously, others asynchronously. One word clears on an active-low reset line instead of the shared active-high one.

The first group of four words exists twice, at 0x0 to 0x3 and at 0x4 to 0x7. A status word inside it is itself doubled. A pair of hardware-written words sits at 0x8 and 0x9. The word at 0xA mixes four byte fields with different access rules. Two of these bytes are shown to hardware through a bypass path, and one raises a notification pulse.

Top module: `cfg_reg_bank`

## Requirements
- R1: A read with `bus_re` high returns the addressed word on `bus_rdata` one cycle later. A cycle without `bus_re` leaves `bus_rdata` at zero on the following cycle.
- R2: Addresses 0xC to 0xF read as zero, and writes to them change no word.
- R3: Software writes to the hardware-owned words leave them unchanged. These words are the capture words at 0x0 and 0x4, the status words at 0x2, 0x3, 0x6 and 0x7, the group words at 0x8 and 0x9, the tail word at 0xB, and bits 31:24 of 0xA.
- R4: The control words at 0x1 and 0x5 take software writes and hardware writes. Their values appear on `hw_ctrl_q`, with 0x1 in bits 31:0 and 0x5 in bits 63:32.
- R5: When software and hardware write the same field in the same cycle, the field takes the hardware data.
- R6: Bits 23:16 of 0xA are write-one-to-clear for software. Each 1 in `bus_wdata[23:16]` clears that bit, and each 0 leaves it unchanged.
- R7: `hw_mix_q` carries the following fields of 0xA:
  - bits 31:24: the registered value of field bits 31:24;
  - bits 23:16 and 7:0: the value those fields will hold after the coming rising edge, shown in the same cycle as the write;
  - bits 15:8: always zero.
- R8: Each software write to 0xA raises `hw_mix_pulse` for exactly the following cycle.
- R9: The capture words update on the falling clock edge. A hardware write and a read of the same capture word in one cycle return the new value.
- R10: All fields reset to zero.
  - `rst` (active high) clears every word except 0xB.
  - `rst_n` (active low) clears only 0xB.
  - The control, status and group words clear asynchronously, before the next clock edge.
  - The word at 0xA clears at the next rising edge.
- R11: Replicated words are independent. Hardware write index k of the capture, control, status and group ports maps, in index order, to addresses {0x0,0x4}, {0x1,0x5}, {0x2,0x3,0x6,0x7} and {0x8,0x9}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset for all words except 0xB |
| rst_n | input | 1 | Active-low reset for word 0xB |
| bus_addr | input | 4 | Software word address |
| bus_we | input | 1 | Software write strobe |
| bus_wdata | input | 32 | Software write data |
| bus_re | input | 1 | Software read enable |
| bus_rdata | output | 32 | Read data, one cycle after `bus_re` |
| hw_capt_we | input | 2 | Hardware write strobes, capture words |
| hw_capt_wd | input | 64 | Hardware write data, capture words (32 bits each) |
| hw_ctrl_we | input | 2 | Hardware write strobes, control words |
| hw_ctrl_wd | input | 64 | Hardware write data, control words |
| hw_ctrl_q | output | 64 | Control word values |
| hw_stat_we | input | 4 | Hardware write strobes, status words |
| hw_stat_wd | input | 128 | Hardware write data, status words |
| hw_grp_we | input | 2 | Hardware write strobes, group words |
| hw_grp_wd | input | 64 | Hardware write data, group words |
| hw_mix_we | input | 4 | Per-byte hardware write strobes for word 0xA |
| hw_mix_wd | input | 32 | Hardware write data for word 0xA |
| hw_mix_q | output | 32 | Hardware view of word 0xA |
| hw_mix_pulse | output | 1 | One-cycle pulse after a software write to 0xA |
| hw_tail_we | input | 1 | Hardware write strobe, word 0xB |
| hw_tail_wd | input | 32 | Hardware write data, word 0xB |

## Verification
Each result is due at a different point after its stimulus:
- Read data for an address presented in cycle n appears in cycle n+1.
- A posedge word written in cycle n reads back through a read issued in cycle n+1 or later.
- A capture word written in cycle n is already visible to a read issued in cycle n, because the falling edge falls inside that cycle.
- The bypass bytes of `hw_mix_q` follow the inputs within cycle n.
- The notification pulse appears in cycle n+1.
- An asynchronous clear shows before the next edge.

The bench drives inputs just after the rising edge and compares every output three quarters into the cycle. That point lies after the falling edge and before the next rising edge. There the behavioural model has applied exactly the falling-edge and combinational effects that the hardware has.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int DW      = 32;
  localparam int AW      = 4;
  localparam int NWORDS  = 12;
  localparam int NCOPY_A = 2;
  localparam int NSTAT   = 2;
  localparam int NGRP    = 2;
  localparam int A_STRIDE = 4;
  localparam int OFS_CAPT = 0;
  localparam int OFS_CTRL = 1;
  localparam int OFS_STAT = 2;
  localparam int GRP_BASE = 8;
  localparam int MIX_ADDR = 10;
  localparam int TAIL_ADDR = 11;
  localparam int BYTE_W = 8;
  localparam int NBYTES = DW / BYTE_W;
endpackage

// File: rtl/rb_field.sv
module rb_field #(
  parameter int W         = 32,
  parameter bit NEG_EDGE  = 1'b0,
  parameter bit ASYNC_RST = 1'b1,
  parameter bit RST_HIGH  = 1'b1,
  parameter bit SW_WR     = 1'b1,
  parameter bit SW_W1C    = 1'b0
) (
  input  logic         clk,
  input  logic         rst_in,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wd,
  input  logic         hw_we,
  input  logic [W-1:0] hw_wd,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  logic rst_act;
  logic sw_hit;

  assign rst_act = RST_HIGH ? rst_in : ~rst_in;
  assign sw_hit  = SW_WR && sw_we;

  // hardware has priority over software
  always_comb begin
    if (hw_we)       nxt = hw_wd;
    else if (sw_hit) nxt = SW_W1C ? (q & ~sw_wd) : sw_wd;
    else             nxt = q;
  end

  if (NEG_EDGE) begin : g_neg
    if (ASYNC_RST) begin : g_async
      always_ff @(negedge clk or posedge rst_act)
        if (rst_act) q <= '0;
        else         q <= nxt;
    end else begin : g_sync
      always_ff @(negedge clk)
        if (rst_act) q <= '0;
        else         q <= nxt;
    end

    AST_HW_WINS_N: assert property (@(negedge clk) disable iff (rst_act)
      hw_we |=> q == $past(hw_wd)) else $error("hw write lost"); // R5
    AST_HOLD_N: assert property (@(negedge clk) disable iff (rst_act)
      (!hw_we && !(SW_WR && sw_we)) |=> $stable(q)) else $error("field moved without write"); // R3
  end else begin : g_pos
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or posedge rst_act)
        if (rst_act) q <= '0;
        else         q <= nxt;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (rst_act) q <= '0;
        else         q <= nxt;
    end

    AST_HW_WINS: assert property (@(posedge clk) disable iff (rst_act)
      hw_we |=> q == $past(hw_wd)) else $error("hw write lost"); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (rst_act)
      (!hw_we && !(SW_WR && sw_we)) |=> $stable(q)) else $error("field moved without write"); // R3
    AST_SW_WRITE: assert property (@(posedge clk) disable iff (rst_act)
      (SW_WR && !SW_W1C && sw_we && !hw_we) |=> q == $past(sw_wd)) else $error("sw write lost"); // R4
    AST_W1C: assert property (@(posedge clk) disable iff (rst_act)
      (SW_W1C && sw_we && !hw_we) |=> (q & $past(sw_wd)) == '0) else $error("w1c bit survived"); // R6
  end
endmodule

// File: rtl/rb_decode.sv
module rb_decode #(
  parameter int AW = 4,
  parameter int N  = 12
) (
  input  logic [AW-1:0] addr,
  input  logic          we,
  output logic [N-1:0]  wr_sel
);
  always_comb begin
    wr_sel = '0;
    for (int i = 0; i < N; i++)
      wr_sel[i] = we && (addr == AW'(i));
  end
endmodule

// File: rtl/rb_rdmux.sv
module rb_rdmux #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int N  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] words [N],
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < N; i++)
      if (addr == AW'(i)) pick = words[i];
  end

  always_ff @(posedge clk)
    if (rst)     rdata <= '0;
    else if (re) rdata <= pick;
    else         rdata <= '0;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !re |=> rdata == '0) else $error("rdata not idle"); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (re && int'(addr) >= N) |=> rdata == '0) else $error("unmapped read nonzero"); // R2
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_n,
  input  logic [3:0]    bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_re,
  output logic [31:0]   bus_rdata,
  input  logic [1:0]    hw_capt_we,
  input  logic [63:0]   hw_capt_wd,
  input  logic [1:0]    hw_ctrl_we,
  input  logic [63:0]   hw_ctrl_wd,
  output logic [63:0]   hw_ctrl_q,
  input  logic [3:0]    hw_stat_we,
  input  logic [127:0]  hw_stat_wd,
  input  logic [1:0]    hw_grp_we,
  input  logic [63:0]   hw_grp_wd,
  input  logic [3:0]    hw_mix_we,
  input  logic [31:0]   hw_mix_wd,
  output logic [31:0]   hw_mix_q,
  output logic          hw_mix_pulse,
  input  logic          hw_tail_we,
  input  logic [31:0]   hw_tail_wd
);
  localparam int NSTAT_ALL = NCOPY_A * NSTAT;

  logic [NWORDS-1:0] wr_sel;
  logic [DW-1:0]     words [NWORDS];
  logic [DW-1:0]     unused_nxt [NWORDS];
  logic [BYTE_W-1:0] mix_q   [NBYTES];
  logic [BYTE_W-1:0] mix_nxt [NBYTES];

  rb_decode #(.AW(AW), .N(NWORDS)) u_dec (
    .addr(bus_addr), .we(bus_we), .wr_sel(wr_sel)
  );

  // replicated first sub-block
  for (genvar k = 0; k < NCOPY_A; k++) begin : g_blk_a
    localparam int BASE = k * A_STRIDE;

    rb_field #(.W(DW), .NEG_EDGE(1'b1), .ASYNC_RST(1'b0), .RST_HIGH(1'b1),
               .SW_WR(1'b0), .SW_W1C(1'b0)) u_capt (
      .clk(clk), .rst_in(rst), .sw_we(wr_sel[BASE+OFS_CAPT]), .sw_wd(bus_wdata),
      .hw_we(hw_capt_we[k]), .hw_wd(hw_capt_wd[DW*k +: DW]),
      .q(words[BASE+OFS_CAPT]), .nxt(unused_nxt[BASE+OFS_CAPT])
    );

    rb_field #(.W(DW), .NEG_EDGE(1'b0), .ASYNC_RST(1'b1), .RST_HIGH(1'b1),
               .SW_WR(1'b1), .SW_W1C(1'b0)) u_ctrl (
      .clk(clk), .rst_in(rst), .sw_we(wr_sel[BASE+OFS_CTRL]), .sw_wd(bus_wdata),
      .hw_we(hw_ctrl_we[k]), .hw_wd(hw_ctrl_wd[DW*k +: DW]),
      .q(words[BASE+OFS_CTRL]), .nxt(unused_nxt[BASE+OFS_CTRL])
    );
    assign hw_ctrl_q[DW*k +: DW] = words[BASE+OFS_CTRL];

    for (genvar j = 0; j < NSTAT; j++) begin : g_stat
      localparam int IDX = k * NSTAT + j;
      rb_field #(.W(DW), .NEG_EDGE(1'b0), .ASYNC_RST(1'b1), .RST_HIGH(1'b1),
                 .SW_WR(1'b0), .SW_W1C(1'b0)) u_stat (
        .clk(clk), .rst_in(rst), .sw_we(wr_sel[BASE+OFS_STAT+j]), .sw_wd(bus_wdata),
        .hw_we(hw_stat_we[IDX]), .hw_wd(hw_stat_wd[DW*IDX +: DW]),
        .q(words[BASE+OFS_STAT+j]), .nxt(unused_nxt[BASE+OFS_STAT+j])
      );
    end
  end

  // grouped words of the second sub-block
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    rb_field #(.W(DW), .NEG_EDGE(1'b0), .ASYNC_RST(1'b1), .RST_HIGH(1'b1),
               .SW_WR(1'b0), .SW_W1C(1'b0)) u_grp (
      .clk(clk), .rst_in(rst), .sw_we(wr_sel[GRP_BASE+g]), .sw_wd(bus_wdata),
      .hw_we(hw_grp_we[g]), .hw_wd(hw_grp_wd[DW*g +: DW]),
      .q(words[GRP_BASE+g]), .nxt(unused_nxt[GRP_BASE+g])
    );
  end

  // mixed byte word: byte 3 sw read-only, byte 2 w1c, bytes 1 and 0 read/write
  for (genvar b = 0; b < NBYTES; b++) begin : g_mix
    rb_field #(.W(BYTE_W), .NEG_EDGE(1'b0), .ASYNC_RST(1'b0), .RST_HIGH(1'b1),
               .SW_WR(b != 3), .SW_W1C(b == 2)) u_byte (
      .clk(clk), .rst_in(rst), .sw_we(wr_sel[MIX_ADDR]), .sw_wd(bus_wdata[BYTE_W*b +: BYTE_W]),
      .hw_we(hw_mix_we[b]), .hw_wd(hw_mix_wd[BYTE_W*b +: BYTE_W]),
      .q(mix_q[b]), .nxt(mix_nxt[b])
    );
    assign words[MIX_ADDR][BYTE_W*b +: BYTE_W] = mix_q[b];
  end
  assign unused_nxt[MIX_ADDR] = {mix_nxt[3], mix_nxt[2], mix_nxt[1], mix_nxt[0]};
  assign hw_mix_q = {mix_q[3], mix_nxt[2], {BYTE_W{1'b0}}, mix_nxt[0]};

  always_ff @(posedge clk)
    if (rst) hw_mix_pulse <= 1'b0;
    else     hw_mix_pulse <= wr_sel[MIX_ADDR];

  // tail word on its own active-low reset
  rb_field #(.W(DW), .NEG_EDGE(1'b0), .ASYNC_RST(1'b1), .RST_HIGH(1'b0),
             .SW_WR(1'b0), .SW_W1C(1'b0)) u_tail (
    .clk(clk), .rst_in(rst_n), .sw_we(wr_sel[TAIL_ADDR]), .sw_wd(bus_wdata),
    .hw_we(hw_tail_we), .hw_wd(hw_tail_wd),
    .q(words[TAIL_ADDR]), .nxt(unused_nxt[TAIL_ADDR])
  );

  rb_rdmux #(.DW(DW), .AW(AW), .N(NWORDS)) u_rd (
    .clk(clk), .rst(rst), .re(bus_re), .addr(bus_addr), .words(words), .rdata(bus_rdata)
  );

  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'(MIX_ADDR)) |=> hw_mix_pulse) else $error("no pulse"); // R8
  AST_PULSE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == 4'(MIX_ADDR)) |=> !hw_mix_pulse) else $error("stray pulse"); // R8
  AST_BYPASS_B2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mix_q[2] == $past(hw_mix_q[23:16])) else $error("bypass b2 mismatch"); // R7
  AST_BYPASS_B0: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mix_q[0] == $past(hw_mix_q[7:0])) else $error("bypass b0 mismatch"); // R7
endmodule

// File: tb/tb_cfg_reg_bank.sv
`timescale 1ns/1ps
module tb_cfg_reg_bank;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] hw_capt_we = '0;  logic [63:0] hw_capt_wd = '0;
  logic [1:0] hw_ctrl_we = '0;  logic [63:0] hw_ctrl_wd = '0;
  logic [63:0] hw_ctrl_q;
  logic [3:0] hw_stat_we = '0;  logic [127:0] hw_stat_wd = '0;
  logic [1:0] hw_grp_we = '0;   logic [63:0] hw_grp_wd = '0;
  logic [3:0] hw_mix_we = '0;   logic [31:0] hw_mix_wd = '0;
  logic [31:0] hw_mix_q;
  logic hw_mix_pulse;
  logic hw_tail_we = 1'b0;      logic [31:0] hw_tail_wd = '0;

  always #(TCK/2) clk = ~clk;

  cfg_reg_bank dut (
    .clk(clk), .rst(rst), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .hw_capt_we(hw_capt_we), .hw_capt_wd(hw_capt_wd),
    .hw_ctrl_we(hw_ctrl_we), .hw_ctrl_wd(hw_ctrl_wd), .hw_ctrl_q(hw_ctrl_q),
    .hw_stat_we(hw_stat_we), .hw_stat_wd(hw_stat_wd),
    .hw_grp_we(hw_grp_we), .hw_grp_wd(hw_grp_wd),
    .hw_mix_we(hw_mix_we), .hw_mix_wd(hw_mix_wd), .hw_mix_q(hw_mix_q), .hw_mix_pulse(hw_mix_pulse),
    .hw_tail_we(hw_tail_we), .hw_tail_wd(hw_tail_wd)
  );

  // behavioural reference state
  logic [31:0] m_capt [2];
  logic [31:0] m_ctrl [2];
  logic [31:0] m_stat [4];
  logic [31:0] m_grp  [2];
  logic [31:0] m_mix, m_tail, m_rd;
  logic        m_pulse;
  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 1'b0;
  string req = "R10";

  function automatic logic [31:0] ref_read(logic [3:0] a);
    case (a)
      4'h0: return m_capt[0];
      4'h4: return m_capt[1];
      4'h1: return m_ctrl[0];
      4'h5: return m_ctrl[1];
      4'h2: return m_stat[0];
      4'h3: return m_stat[1];
      4'h6: return m_stat[2];
      4'h7: return m_stat[3];
      4'h8: return m_grp[0];
      4'h9: return m_grp[1];
      4'hA: return m_mix;
      4'hB: return m_tail;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // entered at rising edge + 2ns with inputs already driven
  task automatic tick();
    logic [7:0] n2, n0, n1, n3;
    logic sww;
    #13;
    for (int k = 0; k < 2; k++)
      if (rst) m_capt[k] = '0;
      else if (hw_capt_we[k]) m_capt[k] = hw_capt_wd[32*k +: 32];
    if (rst) begin
      for (int k = 0; k < 2; k++) begin m_ctrl[k] = '0; m_grp[k] = '0; end
      for (int k = 0; k < 4; k++) m_stat[k] = '0;
    end
    if (!rst_n) m_tail = '0;
    sww = bus_we && bus_addr == 4'hA;
    n3 = hw_mix_we[3] ? hw_mix_wd[31:24] : m_mix[31:24];
    n2 = hw_mix_we[2] ? hw_mix_wd[23:16] : sww ? (m_mix[23:16] & ~bus_wdata[23:16]) : m_mix[23:16];
    n1 = hw_mix_we[1] ? hw_mix_wd[15:8]  : sww ? bus_wdata[15:8] : m_mix[15:8];
    n0 = hw_mix_we[0] ? hw_mix_wd[7:0]   : sww ? bus_wdata[7:0]  : m_mix[7:0];
    if (cmp_on) begin
      chk("bus_rdata", {32'h0, bus_rdata}, {32'h0, m_rd});
      chk("hw_ctrl_q", hw_ctrl_q, {m_ctrl[1], m_ctrl[0]});
      chk("hw_mix_q", {32'h0, hw_mix_q}, {32'h0, m_mix[31:24], n2, 8'h00, n0});
      chk("hw_mix_pulse", {63'h0, hw_mix_pulse}, {63'h0, m_pulse});
    end
    @(posedge clk);
    m_rd    = (rst || !bus_re) ? 32'h0 : ref_read(bus_addr);
    m_pulse = !rst && sww;
    if (!rst) begin
      for (int k = 0; k < 2; k++) begin
        if (hw_ctrl_we[k]) m_ctrl[k] = hw_ctrl_wd[32*k +: 32];
        else if (bus_we && bus_addr == 4'(4*k+1)) m_ctrl[k] = bus_wdata;
        if (hw_grp_we[k]) m_grp[k] = hw_grp_wd[32*k +: 32];
      end
      for (int k = 0; k < 4; k++)
        if (hw_stat_we[k]) m_stat[k] = hw_stat_wd[32*k +: 32];
      m_mix = {n3, n2, n1, n0};
    end else m_mix = '0;
    if (rst_n && hw_tail_we) m_tail = hw_tail_wd;
    #2;
  endtask

  task automatic idle();
    bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    hw_capt_we = '0; hw_ctrl_we = '0; hw_stat_we = '0; hw_grp_we = '0;
    hw_mix_we = '0; hw_tail_we = 1'b0;
  endtask

  task automatic sw_wr(logic [3:0] a, logic [31:0] d);
    idle(); bus_we = 1; bus_addr = a; bus_wdata = d; tick();
  endtask

  task automatic sw_rd(logic [3:0] a);
    idle(); bus_re = 1; bus_addr = a; tick();
  endtask

  initial begin : watchdog
    #(TCK * 50000);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    for (int k = 0; k < 2; k++) begin m_capt[k] = '0; m_ctrl[k] = '0; m_grp[k] = '0; end
    for (int k = 0; k < 4; k++) m_stat[k] = '0;
    m_mix = '0; m_tail = '0; m_rd = '0; m_pulse = 1'b0;
    @(posedge clk); #2;
    tick(); tick();
    cmp_on = 1'b1;
    tick();
    rst = 1'b0; rst_n = 1'b1;
    tick();

    req = "R10";   // every word zero after reset
    for (int a = 0; a < 12; a++) sw_rd(4'(a));

    req = "R9";    // falling-edge capture visible to a read in the same cycle
    idle(); hw_capt_we = 2'b11; hw_capt_wd = {32'hBBBB_0004, 32'hAAAA_0000};
    bus_re = 1; bus_addr = 4'h0; tick();
    req = "R11"; sw_rd(4'h4);

    req = "R4";
    sw_wr(4'h1, 32'h1234_5678);
    sw_wr(4'h5, 32'h9ABC_DEF0);
    idle(); hw_ctrl_we = 2'b10; hw_ctrl_wd = {32'h0F0F_0F0F, 32'h0}; tick();
    sw_rd(4'h1); sw_rd(4'h5);

    req = "R5";
    idle(); bus_we = 1; bus_addr = 4'h1; bus_wdata = 32'hDEAD_BEEF;
    hw_ctrl_we = 2'b01; hw_ctrl_wd = {32'h0, 32'hCAFE_F00D}; tick();
    sw_rd(4'h1);
    idle(); bus_we = 1; bus_addr = 4'hA; bus_wdata = 32'h0000_00AA;
    hw_mix_we = 4'b0001; hw_mix_wd = 32'h0000_0055; tick();

    req = "R11";
    idle(); hw_stat_we = 4'hF;
    hw_stat_wd = {32'h7777_0007, 32'h6666_0006, 32'h3333_0003, 32'h2222_0002};
    hw_grp_we = 2'b11; hw_grp_wd = {32'h9999_0009, 32'h8888_0008};
    hw_tail_we = 1'b1; hw_tail_wd = 32'hBBBB_000B; tick();
    for (int a = 2; a < 12; a++) sw_rd(4'(a));

    req = "R3";
    foreach (m_stat[i]) sw_wr(4'(i < 2 ? 2 + i : 4 + i), 32'hFFFF_FFFF);
    sw_wr(4'h0, 32'h1111_1111); sw_wr(4'h8, 32'h0); sw_wr(4'h9, 32'h0); sw_wr(4'hB, 32'h0);
    for (int a = 0; a < 12; a++) sw_rd(4'(a));

    req = "R6";
    idle(); hw_mix_we = 4'b1100; hw_mix_wd = 32'hC3FF_0000; tick();
    sw_wr(4'hA, 32'h55A5_1234);
    sw_rd(4'hA);
    sw_wr(4'hA, 32'h0000_1234);
    sw_rd(4'hA);

    req = "R7";
    idle(); hw_mix_we = 4'b0101; hw_mix_wd = 32'h00EE_0077; tick();
    idle(); hw_mix_we = 4'b1010; hw_mix_wd = 32'h4400_9900; tick();
    sw_rd(4'hA);

    req = "R8";
    sw_wr(4'hA, 32'h0);
    sw_wr(4'hA, 32'h0);
    tick(); tick();

    req = "R2";
    sw_wr(4'hC, 32'hFFFF_FFFF); sw_wr(4'hF, 32'hFFFF_FFFF);
    for (int a = 12; a < 16; a++) sw_rd(4'(a));
    sw_rd(4'h1);

    req = "R1";
    idle(); bus_addr = 4'h5; tick(); tick();

    req = "R10";   // active-low line clears only the tail word
    idle(); rst_n = 1'b0; bus_re = 1; bus_addr = 4'hB; tick();
    idle(); rst_n = 1'b1; bus_re = 1; bus_addr = 4'h5; tick();
    sw_rd(4'hB);
    idle(); hw_tail_we = 1'b1; hw_tail_wd = 32'h5A5A_5A5A; tick();
    idle(); rst = 1'b1; tick();   // async clear shows on hw_ctrl_q before the edge
    idle(); rst = 1'b0; tick();
    for (int a = 0; a < 12; a++) sw_rd(4'(a));
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule